// File: doc/BRIEF.md
# Receive Queue with Trigger Level and Character Timeout

This block is the receive-side byte queue of a 16550-style serial port. It sits between a deserializer that delivers complete characters and the host register interface. Received bytes are queued in arrival order, and the host pops them with a read strobe. The block reports four things: how full the queue is, whether a programmable fill threshold has been reached, whether bytes were lost or a line break was seen, and whether data has sat unread for too long.

A line break arrives on its own strobe and is queued as a zero byte. The idle timeout is counted in bit-time enable pulses supplied from outside. Its length is four character times, and one character time is worked out from the live frame-format inputs. Interrupt prioritisation and the serial deserializer belong to neighbouring blocks.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: `trig_hit` reflects the stored threshold code, which is loaded from `fcr_level_sel` on every `fcr_we`. The codes map as follows: 2'b00 is 1 byte, 2'b01 is 4 bytes, 2'b10 is 8 bytes and 2'b11 is 14 bytes. While the stored enable is 1, `trig_hit` is high when `fill_level` is at least the selected count. While the stored enable is 0, `trig_hit` is high whenever `fill_level` is non-zero.
- R2: The queue holds up to 16 bytes and returns them in arrival order. `fill_level` gives the number held, registered one cycle after the push or pop. All outputs are 0 after a synchronous reset.
- R3: A byte that arrives while the queue is full and no pop happens in the same cycle is discarded. `overrun` is set and the queued contents stay unchanged.
- R4: A `rx_break` pulse queues a 0x00 byte, with the same full-queue rules as a data byte, and sets `break_seen`. When `rx_break` and `rx_valid` are both high, only the zero byte is queued.
- R5: The timer is restarted by every accepted byte and by every pop that leaves data in the queue. Once it has counted 4 × frame-length `bit_tick` pulses with no further restart, and the queue still holds data, `tmo_pending` is set. The timer stops when the queue becomes empty.
- R6: `data_ready` is high exactly when the queue holds at least one byte. `break_seen` is cleared by a pop that empties the queue.
- R7: `rd_byte` shows the oldest queued byte without delay, and shows 0x00 when the queue is empty. Any `host_rd` pulse, including one on an empty queue, clears `tmo_pending` on the next cycle.
- R8: An `fcr_we` with `fcr_clear` high, or with `fcr_enable` different from the stored enable, flushes the queue. A flush clears `break_seen`, the timer and `tmo_pending`. Any push or pop in that same cycle is discarded. `overrun` is not affected by a flush.
- R9: The frame length is 1 + (`word_len` + 5) + `parity_en` + (`two_stop` ? 2 : 1) bits. It ranges from 7 to 12 bits, so the timeout ranges from 28 to 48 ticks.
- R10: `lsr_rd` clears `overrun` and `break_seen`. A new drop or break in the same cycle wins over the clear.
- R11: On a full queue, a push and a pop in the same cycle both take effect. `fill_level` stays at 16 and `overrun` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | 8 | Received character |
| rx_break | input | 1 | Line-break event strobe |
| host_rd | input | 1 | Host read of the receive data register (pops) |
| lsr_rd | input | 1 | Host read of the line status register |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_enable | input | 1 | FIFO enable value written |
| fcr_clear | input | 1 | Receive flush request |
| fcr_level_sel | input | 2 | Trigger threshold code |
| word_len | input | 2 | Data bits minus five |
| two_stop | input | 1 | Two stop bits |
| parity_en | input | 1 | Parity bit present |
| bit_tick | input | 1 | One pulse per bit time |
| rd_byte | output | 8 | Oldest queued byte, 0 when empty |
| fill_level | output | 5 | Bytes held |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | A byte was dropped |
| break_seen | output | 1 | Break received |
| trig_hit | output | 1 | Threshold reached |
| tmo_pending | output | 1 | Character timeout expired |

## Verification
The bench targets the full-queue edge in several ways: a push alone, a push with a pop in the same cycle, and a break arriving on a full queue. A design that overwrote the oldest byte would show a changed read order. A design that flagged overrun on the paired push and pop would raise `overrun` where it should stay low. The timeout is tested with a short frame and a long frame, with ticks at different rates, and with a pop partway through the count that restarts the timer. An expiry that fired one tick early or late, or that ignored the restart, would show `tmo_pending` in the wrong cycle. The bench also performs flushes caused by an enable toggle, and checks that `overrun` survives them, and it issues a status read in the same cycle as a break to check that the new break wins.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int BYTE_W         = 8;
    localparam int MAX_FRAME_BITS = 12;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic       parity_en;
        logic       two_stop;
        logic [1:0] word_len;
    } line_fmt_t;

    typedef struct packed {
        logic push_req;
        logic push_acc;
        logic pop;
        logic drop;
        logic flush;
    } qop_t;

    function automatic int unsigned trig_bytes(trig_sel_e sel);
        case (sel)
            TRIG_ONE:   return 1;
            TRIG_FOUR:  return 4;
            TRIG_EIGHT: return 8;
            default:    return 14;
        endcase
    endfunction

    function automatic int unsigned frame_bits(line_fmt_t f);
        int unsigned n;
        n = 1 + 5 + int'(f.word_len);
        if (f.parity_en) n = n + 1;
        n = n + (f.two_stop ? 2 : 1);
        return n;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head = (count == '0) ? '0 : mem[rptr];

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_full_push_paired_R11: assert property (@(posedge clk) disable iff (rst)
        (push && !clear && count == CNT_W'(DEPTH)) |-> pop);

endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          arm,
    input  logic          hold_data,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic          armed;
    logic [TW-1:0] elapsed;
    logic          last_tick;

    assign last_tick = (elapsed + TW'(1)) >= limit;
    assign expire    = armed && tick && last_tick && !arm && !clear && hold_data;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed   <= 1'b0;
            elapsed <= '0;
        end else if (arm) begin
            armed   <= 1'b1;
            elapsed <= '0;
        end else if (!hold_data) begin
            armed   <= 1'b0;
            elapsed <= '0;
        end else if (armed && tick) begin
            if (last_tick) begin
                armed   <= 1'b0;
                elapsed <= '0;
            end else begin
                elapsed <= elapsed + TW'(1);
            end
        end
    end

    assert_restart_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
        (arm && !clear) |=> (armed && elapsed == '0));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic drop,
    input  logic brk_evt,
    input  logic lsr_rd,
    input  logic emptied,
    input  logic rd,
    input  logic expire,
    output logic oe,
    output logic brk,
    output logic tmo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            oe  <= 1'b0;
            brk <= 1'b0;
            tmo <= 1'b0;
        end else begin
            if (drop)        oe <= 1'b1;
            else if (lsr_rd) oe <= 1'b0;

            if (flush)                  brk <= 1'b0;
            else if (brk_evt)           brk <= 1'b1;
            else if (lsr_rd || emptied) brk <= 1'b0;

            if (flush || rd) tmo <= 1'b0;
            else if (expire) tmo <= 1'b1;
        end
    end

    assert_lsr_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !drop) |=> !oe);

    assert_read_clears_tmo_R7: assert property (@(posedge clk) disable iff (rst)
        rd |=> !tmo);

endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo #(
    parameter int DEPTH     = 16,
    parameter int TMO_CHARS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_byte,
    input  logic                       rx_break,
    input  logic                       host_rd,
    input  logic                       lsr_rd,
    input  logic                       fcr_we,
    input  logic                       fcr_enable,
    input  logic                       fcr_clear,
    input  logic [1:0]                 fcr_level_sel,
    input  logic [1:0]                 word_len,
    input  logic                       two_stop,
    input  logic                       parity_en,
    input  logic                       bit_tick,
    output logic [7:0]                 rd_byte,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic                       data_ready,
    output logic                       overrun,
    output logic                       break_seen,
    output logic                       trig_hit,
    output logic                       tmo_pending
);
    import rxq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CW1   = CNT_W + 1;
    localparam int TMO_W = $clog2(TMO_CHARS * MAX_FRAME_BITS + 1);

    logic        en_q;
    trig_sel_e   trig_q;
    line_fmt_t   fmt;
    qop_t        op;
    logic        full;
    logic [7:0]  push_byte;
    logic [CW1-1:0]   cnt_nx;
    logic             emptied, arm, hold_data, expire;
    logic [TMO_W-1:0] limit;

    assign fmt  = '{parity_en: parity_en, two_stop: two_stop, word_len: word_len};
    assign full = (fill_level == CNT_W'(DEPTH));

    always_comb begin
        op.flush    = fcr_we && (fcr_clear || (fcr_enable != en_q));
        op.push_req = (rx_valid || rx_break) && !op.flush;
        op.pop      = host_rd && (fill_level != '0) && !op.flush;
        op.push_acc = op.push_req && (!full || op.pop);
        op.drop     = op.push_req && !op.push_acc;
    end

    assign push_byte = rx_break ? 8'h00 : rx_byte;
    assign cnt_nx    = {1'b0, fill_level} + CW1'(op.push_acc) - CW1'(op.pop);
    assign emptied   = op.pop && (cnt_nx == '0);
    assign arm       = op.push_acc || (op.pop && cnt_nx != '0);
    assign hold_data = (cnt_nx != '0);
    assign limit     = TMO_W'(TMO_CHARS * frame_bits(fmt));

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            trig_q <= TRIG_ONE;
        end else if (fcr_we) begin
            en_q   <= fcr_enable;
            trig_q <= trig_sel_e'(fcr_level_sel);
        end
    end

    rxq_store #(.DEPTH(DEPTH), .W(BYTE_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clear (op.flush),
        .push  (op.push_acc),
        .pop   (op.pop),
        .wdata (push_byte),
        .head  (rd_byte),
        .count (fill_level)
    );

    rxq_char_timer #(.TW(TMO_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear     (op.flush),
        .arm       (arm),
        .hold_data (hold_data),
        .tick      (bit_tick),
        .limit     (limit),
        .expire    (expire)
    );

    rxq_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .flush   (op.flush),
        .drop    (op.drop),
        .brk_evt (rx_break && !op.flush),
        .lsr_rd  (lsr_rd),
        .emptied (emptied),
        .rd      (host_rd),
        .expire  (expire),
        .oe      (overrun),
        .brk     (break_seen),
        .tmo     (tmo_pending)
    );

    assign data_ready = (fill_level != '0);
    assign trig_hit   = en_q ? (int'(fill_level) >= int'(trig_bytes(trig_q)))
                             : data_ready;

    assert_drop_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (full && (rx_valid || rx_break) && !host_rd && !fcr_we)
        |=> (overrun && fill_level == CNT_W'(DEPTH)));

    assert_break_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_break && !fcr_we) |=> (break_seen && data_ready));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (fcr_we && fcr_clear) |=> (fill_level == '0 && !break_seen && !tmo_pending));

    assert_full_swap_R11: assert property (@(posedge clk) disable iff (rst)
        (full && rx_valid && host_rd && !fcr_we && !lsr_rd && !overrun)
        |=> (!overrun && fill_level == CNT_W'(DEPTH)));

    assert_tmo_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_pending) |-> data_ready);

endmodule

// File: tb/rxq_trigger_fifo_tb.sv
module rxq_trigger_fifo_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_break = 0, host_rd = 0, lsr_rd = 0;
    logic fcr_we = 0, fcr_enable = 0, fcr_clear = 0;
    logic [1:0] fcr_level_sel = 0, word_len = 0;
    logic two_stop = 0, parity_en = 0, bit_tick = 0;
    logic [7:0] rx_byte = 0;
    logic [7:0] rd_byte;
    logic [4:0] fill_level;
    logic data_ready, overrun, break_seen, trig_hit, tmo_pending;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_trigger_fifo dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .host_rd(host_rd), .lsr_rd(lsr_rd),
        .fcr_we(fcr_we), .fcr_enable(fcr_enable), .fcr_clear(fcr_clear),
        .fcr_level_sel(fcr_level_sel), .word_len(word_len),
        .two_stop(two_stop), .parity_en(parity_en), .bit_tick(bit_tick),
        .rd_byte(rd_byte), .fill_level(fill_level), .data_ready(data_ready),
        .overrun(overrun), .break_seen(break_seen), .trig_hit(trig_hit),
        .tmo_pending(tmo_pending)
    );

    int checks = 0, fails = 0, cyc_no = 0, tick_div = 0;
    string phase = "R2 reset";
    bit finished = 0;

    logic [7:0] q[$];
    int m_en = 0, m_trig = 0, m_oe = 0, m_brk = 0, m_tmo = 0, m_armed = 0, m_elapsed = 0;

    function automatic int lvl(int code);
        case (code) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
    endfunction

    function automatic int tmo_limit();
        int fb;
        fb = 1 + int'(word_len) + 5 + int'(parity_en) + (two_stop ? 2 : 1);
        return 4 * fb;
    endfunction

    task automatic model_step();
        int flush, pushv, popv, acc, drop, sz, fire;
        logic [7:0] pb;
        if (rst) begin
            q.delete(); m_en = 0; m_trig = 0; m_oe = 0; m_brk = 0;
            m_tmo = 0; m_armed = 0; m_elapsed = 0;
            return;
        end
        flush = fcr_we && (fcr_clear || (int'(fcr_enable) != m_en));
        if (fcr_we) begin m_en = int'(fcr_enable); m_trig = int'(fcr_level_sel); end
        if (flush) begin
            q.delete(); m_brk = 0; m_tmo = 0; m_armed = 0; m_elapsed = 0;
            if (lsr_rd) m_oe = 0;
            return;
        end
        pushv = rx_valid || rx_break;
        pb    = rx_break ? 8'h00 : rx_byte;
        popv  = host_rd && q.size() > 0;
        acc   = pushv && (q.size() < DEPTH || popv);
        drop  = pushv && !acc;
        if (popv) void'(q.pop_front());
        if (acc) q.push_back(pb);
        sz = q.size();
        fire = 0;
        if (acc || (popv && sz > 0)) begin m_armed = 1; m_elapsed = 0; end
        else if (sz == 0) begin m_armed = 0; m_elapsed = 0; end
        else if (m_armed && bit_tick) begin
            if (m_elapsed + 1 >= tmo_limit()) begin fire = 1; m_armed = 0; m_elapsed = 0; end
            else m_elapsed++;
        end
        if (drop) m_oe = 1; else if (lsr_rd) m_oe = 0;
        if (rx_break) m_brk = 1; else if (lsr_rd || (popv && sz == 0)) m_brk = 0;
        if (host_rd) m_tmo = 0; else if (fire) m_tmo = 1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d actual=%0d expected=%0d", tag, phase, cyc_no, act, exp);
        end
    endtask

    task automatic compare();
        chk("R7 read data", int'(rd_byte), (q.size() > 0) ? int'(q[0]) : 0);
        chk("R2 fill level", int'(fill_level), q.size());
        chk("R6 data ready", int'(data_ready), q.size() > 0);
        chk("R3 overrun", int'(overrun), m_oe);
        chk("R4 break", int'(break_seen), m_brk);
        chk("R5 timeout", int'(tmo_pending), m_tmo);
        chk("R1 trigger", int'(trig_hit), m_en ? (q.size() >= lvl(m_trig)) : (q.size() > 0));
    endtask

    // one clock: inputs are already set at the current falling edge
    task automatic cyc();
        bit_tick = (tick_div > 0) && (cyc_no % tick_div == 0);
        @(posedge clk);
        model_step();
        @(negedge clk);
        cyc_no++;
        compare();
        rx_valid = 0; rx_break = 0; host_rd = 0; lsr_rd = 0;
        fcr_we = 0; fcr_clear = 0;
    endtask

    task automatic push(logic [7:0] b);
        rx_valid = 1; rx_byte = b; cyc();
    endtask

    task automatic pop();
        host_rd = 1; cyc();
    endtask

    task automatic fcr(logic en, logic clr, logic [1:0] sel);
        fcr_we = 1; fcr_enable = en; fcr_clear = clr; fcr_level_sel = sel; cyc();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic fill(int n, logic [7:0] base);
        for (int i = 0; i < n; i++) push(base + 8'(i));
    endtask

    task automatic drain();
        while (q.size() > 0) pop();
    endtask

    initial begin
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        cyc();

        phase = "R8 enable change flush"; fcr(1, 0, 2'b00);
        phase = "R2 order"; push(8'hA1); push(8'hB2); push(8'hC3); pop(); pop(); pop();
        phase = "R7 empty read returns zero"; pop(); idle(2);

        for (int c = 0; c < 4; c++) begin
            phase = "R1 trigger levels";
            fcr(1, 0, 2'(c));
            fill(15, 8'h10);
            phase = "R8 flush by clear bit"; fcr(1, 1, 2'(c));
        end

        phase = "R3 overrun drop"; fcr(1, 0, 2'b11);
        fill(16, 8'h40); push(8'hEE); push(8'hEF); idle(1);
        phase = "R10 status read clears"; lsr_rd = 1; cyc();
        phase = "R3 contents kept"; drain();

        phase = "R11 full push with pop"; fill(16, 8'h60);
        for (int i = 0; i < 3; i++) begin rx_valid = 1; rx_byte = 8'h90 + 8'(i); host_rd = 1; cyc(); end
        drain();

        phase = "R4 break zero byte"; push(8'h33); rx_break = 1; cyc(); pop(); pop();
        phase = "R4 break plus valid"; rx_break = 1; rx_valid = 1; rx_byte = 8'h77; cyc(); drain();
        phase = "R4 break on full"; fill(16, 8'h20); rx_break = 1; cyc();
        phase = "R10 break wins over status read"; rx_break = 1; lsr_rd = 1; cyc();
        lsr_rd = 1; cyc();
        fcr(1, 1, 2'b00);

        phase = "R9 short frame timeout"; word_len = 0; two_stop = 0; parity_en = 0; tick_div = 1;
        push(8'h01); idle(34);
        phase = "R7 read clears pending"; pop(); idle(3);
        phase = "R5 pop restarts timer"; push(8'h02); push(8'h03); idle(15); pop(); idle(35); pop(); idle(3);
        phase = "R9 long frame timeout"; word_len = 2'b11; two_stop = 1; parity_en = 1; tick_div = 2;
        push(8'h04); idle(100); pop();
        phase = "R9 mid frame"; word_len = 2'b01; two_stop = 1; parity_en = 0; tick_div = 3;
        push(8'h05); idle(110); host_rd = 1; cyc(); tick_div = 0;

        phase = "R8 flush keeps overrun"; fill(17, 8'h80);
        fcr(0, 0, 2'b10);
        phase = "R1 disabled trigger"; push(8'h55); fcr(0, 0, 2'b11); idle(1); pop();
        phase = "R8 flush discards same-cycle push"; push(8'h56); rx_valid = 1; rx_byte = 8'h57; fcr(1, 0, 2'b00);
        lsr_rd = 1; cyc(); idle(2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog [%s] actual=hung expected=done", phase);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule